// File: doc/BRIEF.md
# Dual-Input Cascadable Up/Down Counter

This block is a small binary counter with two separate step inputs. A rising edge on the increment input adds one, and a rising edge on the decrement input subtracts one. A step is taken only if the other step input is high. A parallel preset, active low, loads the count from a data bus. An active-high clear forces the count to zero. Everything runs on one system clock. Both step inputs pass through a resynchronizer and are then edge-detected, so they may be driven from any source.

Two active-low cascade outputs let identical instances be chained with plain wires:

- The overflow output falls while the count is at its maximum and the increment input is low.
- The underflow output falls while the count is zero and the decrement input is low.

When the step input returns high, the cascade output rises together with it. That rising edge is a valid step for the next stage. To build a wider counter, connect each stage's overflow output to the next stage's increment input, and its underflow output to the next stage's decrement input.

Top module: `dual_pulse_counter`

## Requirements
- R1: With the default width of 4 the count wraps in both directions: a step up from 15 gives 0, and a step down from 0 gives 15.
- R2: A rising edge on `up_in` adds one only if `dn_in` is high at that time. A rising edge on `dn_in` subtracts one only if `up_in` is high at that time. An edge that arrives while the opposite input is low leaves `q` unchanged.
- R3: While `load_n` is 0, `q` takes the value of `din` one clock after each edge. A step edge that arrives while `load_n` is 0 is discarded and does not act later.
- R4: While `clr` is 1, `q` becomes 0 at the next clock edge. This holds whatever `load_n`, `din` and the step inputs are doing.
- R5: `carry_n` is 0 exactly while `q` is at its maximum and the resynchronized `up_in` is low. It returns to 1 when `up_in` rises, and the count then wraps to 0.
- R6: `borrow_n` is 0 exactly while `q` is 0 and the resynchronized `dn_in` is low. It returns to 1 when `dn_in` rises, and the count then wraps to the maximum.
- R7: If both step inputs rise in the same sampled cycle, `q` holds its value.
- R8: Two instances can be chained as follows, and they then count as one 8-bit counter in both directions:
  - the low stage's `carry_n` drives the high stage's `up_in`;
  - the low stage's `borrow_n` drives the high stage's `dn_in`.
- R9: After a synchronous reset, `q` is 0 and both `carry_n` and `borrow_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Active-high clear; overrides preset and stepping |
| load_n | input | 1 | Active-low parallel preset enable |
| din | input | WIDTH | Preset data |
| up_in | input | 1 | Increment input; rising edge steps |
| dn_in | input | 1 | Decrement input; rising edge steps |
| q | output | WIDTH | Count value |
| carry_n | output | 1 | Active-low overflow pulse for cascading |
| borrow_n | output | 1 | Active-low underflow pulse for cascading |

## Verification
The bench chains two instances and drives the low stage. It goes after the wrap across the stage boundary in both directions. A wrong cascade pulse there would leave the high nibble stuck, or would step it twice.

Edges that arrive during a preset, while the opposite input is low, or on both inputs at once must not move the count. A design that latched these edges, or let one input win, would show a count that is off by one.

Clear is asserted together with a preset to catch a wrong priority. The low stage's cascade outputs are sampled while a step input is held low, to confirm that the pulse spans that low phase.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/dpc_sync_edge.sv
// Resynchronizes one step input and flags its rising edge.
module dpc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] shr;
  logic              prev;

  // Idle level of a step input is high, so reset to ones: no false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      shr  <= '1;
      prev <= 1'b1;
    end else begin
      shr  <= {shr[LAST-1:0], din};
      prev <= shr[LAST];
    end
  end

  assign lvl  = shr[LAST];
  assign rise = shr[LAST] & ~prev;

  // R2: an edge flag lasts a single cycle
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/dpc_step_decode.sv
// Chooses the step for this cycle from both inputs' edges and levels.
module dpc_step_decode
  import dpc_pkg::*;
(
  input  logic  up_rise,
  input  logic  dn_rise,
  input  logic  up_lvl,
  input  logic  dn_lvl,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (up_rise && !dn_rise && dn_lvl)
      step = STEP_INC;
    else if (dn_rise && !up_rise && up_lvl)
      step = STEP_DEC;
  end
endmodule

// File: rtl/dual_pulse_counter.sv
module dual_pulse_counter
  import dpc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up_in,
  input  logic             dn_in,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int             NCH   = 2;
  localparam int             CH_UP = 0;
  localparam int             CH_DN = 1;
  localparam logic [WIDTH-1:0] Q_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] Q_MIN = '0;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] rise;
  step_e          step;

  assign raw = {dn_in, up_in};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dpc_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[ch]),
      .lvl  (lvl[ch]),
      .rise (rise[ch])
    );
  end

  dpc_step_decode u_dec (
    .up_rise (rise[CH_UP]),
    .dn_rise (rise[CH_DN]),
    .up_lvl  (lvl[CH_UP]),
    .dn_lvl  (lvl[CH_DN]),
    .step    (step)
  );

  // Clear beats preset, and preset beats stepping.
  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= '0;
    else if (!load_n)
      q <= din;
    else begin
      case (step)
        STEP_INC: q <= q + 1'b1;
        STEP_DEC: q <= q - 1'b1;
        default:  q <= q;
      endcase
    end
  end

  // Cascade pulses span the low phase of the synchronized step input.
  assign carry_n  = ~((q == Q_MAX) & ~lvl[CH_UP]);
  assign borrow_n = ~((q == Q_MIN) & ~lvl[CH_DN]);

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == Q_MIN));

  // R3
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (q == $past(din)));

  // R7
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rise[CH_UP] && rise[CH_DN] && !clr && load_n) |=> $stable(q));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise[CH_UP] && !rise[CH_DN] && !clr && load_n) |=> $stable(q));

  // R5
  carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(carry_n) && !clr && load_n && lvl[CH_DN]) |=> (q == Q_MIN));

  // R6
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(borrow_n) && !clr && load_n && lvl[CH_UP]) |=> (q == Q_MAX));
endmodule

// File: tb/sim_dual_pulse_counter.sv
module sim_dual_pulse_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic load_n = 1'b1;
  logic [2*W-1:0] din = '0;
  logic up_in = 1'b1;
  logic dn_in = 1'b1;
  logic [W-1:0] q0, q1;
  logic c0, b0, c1, b1;
  logic [2*W-1:0] value;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_pulse_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .din(din[W-1:0]),
    .up_in(up_in), .dn_in(dn_in), .q(q0), .carry_n(c0), .borrow_n(b0));

  // R8: high stage fed only by the low stage's cascade outputs
  dual_pulse_counter #(.WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .din(din[2*W-1:W]),
    .up_in(c0), .dn_in(b0), .q(q1), .carry_n(c1), .borrow_n(b1));

  assign value = {q1, q0};

  // op codes: 0 up pulse, 1 down pulse, 2 preset, 3 clear
  localparam logic [17:0] VEC [18] = '{
    {2'd3, 8'h00, 8'h00}, {2'd2, 8'h0D, 8'h0D}, {2'd0, 8'h00, 8'h0E},
    {2'd0, 8'h00, 8'h0F}, {2'd0, 8'h00, 8'h10}, {2'd0, 8'h00, 8'h11},
    {2'd0, 8'h00, 8'h12}, {2'd1, 8'h00, 8'h11}, {2'd1, 8'h00, 8'h10},
    {2'd1, 8'h00, 8'h0F}, {2'd1, 8'h00, 8'h0E}, {2'd1, 8'h00, 8'h0D},
    {2'd2, 8'hFF, 8'hFF}, {2'd0, 8'h00, 8'h00}, {2'd1, 8'h00, 8'hFF},
    {2'd2, 8'h00, 8'h00}, {2'd1, 8'h00, 8'hFF}, {2'd3, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up_in = 1'b0; cyc(4); up_in = 1'b1; cyc(12);
  endtask

  task automatic pulse_dn();
    dn_in = 1'b0; cyc(4); dn_in = 1'b1; cyc(12);
  endtask

  task automatic preset(input logic [7:0] d);
    din = d; load_n = 1'b0; cyc(2); load_n = 1'b1; cyc(2);
  endtask

  task automatic clear();
    clr = 1'b1; cyc(2); clr = 1'b0; cyc(2);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R9 reset state
    chk("R9 q", {8'h0, value}, 16'h0000);
    chk("R9 carry_n", {15'h0, c0}, 16'h1);
    chk("R9 borrow_n", {15'h0, b0}, 16'h1);

    // R1 R2 R8 table walk
    for (int i = 0; i < 18; i++) begin
      case (VEC[i][17:16])
        2'd0: pulse_up();
        2'd1: pulse_dn();
        2'd2: preset(VEC[i][15:8]);
        default: clear();
      endcase
      chk($sformatf("R8 R1 vector %0d", i), {8'h0, value}, {8'h0, VEC[i][7:0]});
    end

    // R5 carry low while up is low at the maximum
    preset(8'hFF);
    up_in = 1'b0; cyc(6);
    chk("R5 carry_n low", {15'h0, c0}, 16'h0);
    chk("R5 hold during low", {8'h0, value}, 16'h00FF);
    up_in = 1'b1; cyc(12);
    chk("R5 carry_n high", {15'h0, c0}, 16'h1);
    chk("R5 wrap", {8'h0, value}, 16'h0000);

    // R6 borrow low while down is low at zero
    dn_in = 1'b0; cyc(6);
    chk("R6 borrow_n low", {15'h0, b0}, 16'h0);
    dn_in = 1'b1; cyc(12);
    chk("R6 borrow_n high", {15'h0, b0}, 16'h1);
    chk("R6 wrap", {8'h0, value}, 16'h00FF);

    // R2 up edge ignored while down held low, then down rise steps
    preset(8'h00);
    dn_in = 1'b0; cyc(6);
    pulse_up();
    chk("R2 up ignored", {8'h0, value}, 16'h0000);
    dn_in = 1'b1; cyc(12);
    chk("R2 down rise", {8'h0, value}, 16'h00FF);

    // R7 simultaneous rises hold
    preset(8'h55);
    up_in = 1'b0; dn_in = 1'b0; cyc(4);
    up_in = 1'b1; dn_in = 1'b1; cyc(12);
    chk("R7 both hold", {8'h0, value}, 16'h0055);

    // R3 edge during preset is discarded
    din = 8'h20; load_n = 1'b0; cyc(2);
    up_in = 1'b0; cyc(4); up_in = 1'b1; cyc(6);
    chk("R3 follows din", {8'h0, value}, 16'h0020);
    load_n = 1'b1; cyc(12);
    chk("R3 edge dropped", {8'h0, value}, 16'h0020);

    // R4 clear beats preset
    din = 8'hAA; load_n = 1'b0; clr = 1'b1; cyc(3);
    chk("R4 clear priority", {8'h0, value}, 16'h0000);
    clr = 1'b0; load_n = 1'b1; cyc(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule